// File: doc/BRIEF.md
# Dual-Width Operand Store

This block keeps a small set of wide big-integer operands for a modular multiplier. Each operand slot is a whole number of 32-bit lanes. A narrow 32-bit port fills a slot one lane per cycle, addressed by a slot select and a lane index. The same port reads back one lane of the current result slot. A wide port on the multiplier side sees one whole slot at once, chosen by its own select. It can overwrite one whole slot with a full-width result in a single cycle.

When both sides write in the same cycle, the block raises a collision flag. A mode input forces the result slot to the highest slot index; the surrounding controller uses this for repeated squaring and multiplying. With the mode input low, the result slot comes from the destination select. Both read outputs are registered.

Top module: `operand_store`

## Requirements
- R1: After a synchronous active-high reset, every slot holds zero. The wide output and the narrow read data are zero, and reads of slots not yet written return zero.
- R2: When `lane_we` is 1, lane `lane_idx` of slot `lane_slot` (bits 32*idx+31 down to 32*idx) takes `lane_wdata` at that clock edge. The other lanes and slots keep their contents.
- R3: While `lane_we` and `res_we` are both 0, no slot changes, whatever the data, slot and lane inputs carry.
- R4: `wide_q` is registered. It shows the whole slot picked by `wide_sel`, as it stood before the edge, one clock after the select is applied.
- R5: When `res_we` is 1, `res_wdata` replaces the whole destination slot in one cycle. Other slots are untouched.
- R6: `lane_rdata` is registered. One clock after the inputs are applied, it shows lane `lane_idx` of the destination slot.
- R7: `collision` is a combinational output. It is 1 exactly in cycles where `lane_we` and `res_we` are both 1, whatever slots they target.
- R8: When both writes happen in one cycle, the result write wins on the lanes of its slot. A lane write to a different slot still takes effect.
- R9: When `exp_mode` is 1, the destination slot is N_SLOTS-1 for both the result write and the narrow read, and `res_dest` is ignored. When `exp_mode` is 0, the destination slot is `res_dest`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_we | input | 1 | Narrow-side lane write enable |
| lane_slot | input | SLOT_W | Slot targeted by a lane write |
| lane_idx | input | LANE_W | Lane index for writes and reads |
| lane_wdata | input | 32 | Lane write data |
| lane_rdata | output | 32 | Registered lane of the destination slot |
| wide_sel | input | SLOT_W | Slot shown on the wide output |
| wide_q | output | OP_BITS | Registered full slot contents |
| res_we | input | 1 | Full-width result write enable |
| res_dest | input | SLOT_W | Destination slot when exp_mode is 0 |
| exp_mode | input | 1 | Forces the destination to the top slot |
| res_wdata | input | OP_BITS | Full-width result data |
| collision | output | 1 | Both sides write in this cycle |

## Verification
The bench builds the block with 128-bit operands (four lanes) and four slots. With this size, every lane of every slot can be written with a distinct computed value, and every slot can be compared whole against a bench model. The narrow read can be swept over every lane of each destination. The small size also leaves room to force each pairing of simultaneous writes: same slot and lane, different slots, and the forced top slot in exponentiation mode.

// File: rtl/ostore_pkg.sv
package ostore_pkg;

    localparam int unsigned LANE_BITS = 32;

    typedef logic [LANE_BITS-1:0] lane_t;

    // Per-lane write request, produced by the decoder
    typedef struct packed {
        logic from_res;
        logic from_bus;
    } lane_ctl_t;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_BUS  = 2'd1,
        SRC_RES  = 2'd2
    } wsrc_t;

    function automatic int unsigned addr_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned lanes_of(input int unsigned bits);
        return bits / LANE_BITS;
    endfunction

    // Result write has priority over a narrow lane write
    function automatic wsrc_t pick_src(input lane_ctl_t c);
        if (c.from_res)      return SRC_RES;
        else if (c.from_bus) return SRC_BUS;
        else                 return SRC_HOLD;
    endfunction

endpackage

// File: rtl/ostore_lane_decode.sv
module ostore_lane_decode
    import ostore_pkg::*;
#(
    parameter int unsigned N_SLOTS = 4,
    parameter int unsigned LANES   = 48,
    localparam int unsigned SLOT_W = addr_bits(N_SLOTS),
    localparam int unsigned LANE_W = addr_bits(LANES)
) (
    input  logic                      lane_we,
    input  logic [SLOT_W-1:0]         lane_slot,
    input  logic [LANE_W-1:0]         lane_idx,
    input  logic                      res_we,
    input  logic [SLOT_W-1:0]         res_dest,
    input  logic                      exp_mode,
    output logic [SLOT_W-1:0]         dest_eff,
    output lane_ctl_t [N_SLOTS*LANES-1:0] ctl,
    output logic                      collision
);

    localparam logic [SLOT_W-1:0] TOP_SLOT = SLOT_W'(N_SLOTS - 1);

    assign dest_eff  = exp_mode ? TOP_SLOT : res_dest;
    assign collision = lane_we & res_we;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        localparam logic [SLOT_W-1:0] SID = SLOT_W'(s);
        logic slot_res;
        logic slot_bus;
        assign slot_res = res_we  && (dest_eff  == SID);
        assign slot_bus = lane_we && (lane_slot == SID);
        for (genvar w = 0; w < LANES; w++) begin : g_lane
            localparam logic [LANE_W-1:0] LID = LANE_W'(w);
            assign ctl[s*LANES + w].from_res = slot_res;
            assign ctl[s*LANES + w].from_bus = slot_bus && (lane_idx == LID);
        end
    end

endmodule

// File: rtl/ostore_slot_bank.sv
module ostore_slot_bank
    import ostore_pkg::*;
#(
    parameter int unsigned N_SLOTS = 4,
    parameter int unsigned LANES   = 48,
    localparam int unsigned OP_BITS = LANES * LANE_BITS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  lane_ctl_t [N_SLOTS*LANES-1:0] ctl,
    input  lane_t                         lane_wdata,
    input  logic [OP_BITS-1:0]            res_wdata,
    output logic [N_SLOTS-1:0][OP_BITS-1:0] store
);

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        for (genvar w = 0; w < LANES; w++) begin : g_lane
            lane_t q;
            wsrc_t src;
            assign src = pick_src(ctl[s*LANES + w]);
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    case (src)
                        SRC_RES:  q <= res_wdata[w*LANE_BITS +: LANE_BITS];
                        SRC_BUS:  q <= lane_wdata;
                        default:  q <= q;
                    endcase
                end
            end
            assign store[s][w*LANE_BITS +: LANE_BITS] = q;
        end
    end

endmodule

// File: rtl/ostore_read_port.sv
module ostore_read_port
    import ostore_pkg::*;
#(
    parameter int unsigned N_SLOTS = 4,
    parameter int unsigned LANES   = 48,
    localparam int unsigned OP_BITS = LANES * LANE_BITS,
    localparam int unsigned SLOT_W  = addr_bits(N_SLOTS),
    localparam int unsigned LANE_W  = addr_bits(LANES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_SLOTS-1:0][OP_BITS-1:0] store,
    input  logic [SLOT_W-1:0]               wide_sel,
    input  logic [SLOT_W-1:0]               dest_eff,
    input  logic [LANE_W-1:0]               lane_idx,
    output logic [OP_BITS-1:0]              wide_q,
    output lane_t                           lane_rdata
);

    logic [OP_BITS-1:0] wide_nxt;
    logic [OP_BITS-1:0] dest_slot;
    lane_t              lane_nxt;

    always_comb begin
        wide_nxt  = '0;
        dest_slot = '0;
        for (int s = 0; s < N_SLOTS; s++) begin
            if (wide_sel == SLOT_W'(s)) wide_nxt  = store[s];
            if (dest_eff == SLOT_W'(s)) dest_slot = store[s];
        end
    end

    always_comb begin
        lane_nxt = '0;
        for (int w = 0; w < LANES; w++) begin
            if (lane_idx == LANE_W'(w)) lane_nxt = dest_slot[w*LANE_BITS +: LANE_BITS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q     <= '0;
            lane_rdata <= '0;
        end else begin
            wide_q     <= wide_nxt;
            lane_rdata <= lane_nxt;
        end
    end

endmodule

// File: rtl/operand_store.sv
module operand_store
    import ostore_pkg::*;
#(
    parameter int unsigned OP_BITS = 1536,
    parameter int unsigned N_SLOTS = 4,
    localparam int unsigned LANES  = lanes_of(OP_BITS),
    localparam int unsigned SLOT_W = addr_bits(N_SLOTS),
    localparam int unsigned LANE_W = addr_bits(LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lane_we,
    input  logic [SLOT_W-1:0]  lane_slot,
    input  logic [LANE_W-1:0]  lane_idx,
    input  logic [31:0]        lane_wdata,
    output logic [31:0]        lane_rdata,
    input  logic [SLOT_W-1:0]  wide_sel,
    output logic [OP_BITS-1:0] wide_q,
    input  logic               res_we,
    input  logic [SLOT_W-1:0]  res_dest,
    input  logic               exp_mode,
    input  logic [OP_BITS-1:0] res_wdata,
    output logic               collision
);

    if ((OP_BITS % LANE_BITS) != 0 || OP_BITS < LANE_BITS) begin : g_bad_width
        $error("OP_BITS must be a nonzero multiple of 32");
    end
    if (N_SLOTS < 2) begin : g_bad_slots
        $error("N_SLOTS must be at least 2");
    end

    logic [SLOT_W-1:0]               dest_eff;
    lane_ctl_t [N_SLOTS*LANES-1:0]   ctl;
    logic [N_SLOTS-1:0][OP_BITS-1:0] store;

    ostore_lane_decode #(.N_SLOTS(N_SLOTS), .LANES(LANES)) u_dec (
        .lane_we   (lane_we),
        .lane_slot (lane_slot),
        .lane_idx  (lane_idx),
        .res_we    (res_we),
        .res_dest  (res_dest),
        .exp_mode  (exp_mode),
        .dest_eff  (dest_eff),
        .ctl       (ctl),
        .collision (collision)
    );

    ostore_slot_bank #(.N_SLOTS(N_SLOTS), .LANES(LANES)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .lane_wdata (lane_wdata),
        .res_wdata  (res_wdata),
        .store      (store)
    );

    ostore_read_port #(.N_SLOTS(N_SLOTS), .LANES(LANES)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .store      (store),
        .wide_sel   (wide_sel),
        .dest_eff   (dest_eff),
        .lane_idx   (lane_idx),
        .wide_q     (wide_q),
        .lane_rdata (lane_rdata)
    );

endmodule

// File: rtl/operand_store_chk.sv
module operand_store_chk
    import ostore_pkg::*;
#(
    parameter int unsigned OP_BITS = 1536,
    parameter int unsigned N_SLOTS = 4,
    localparam int unsigned LANES  = lanes_of(OP_BITS),
    localparam int unsigned SLOT_W = addr_bits(N_SLOTS),
    localparam int unsigned LANE_W = addr_bits(LANES)
) (
    input logic               clk,
    input logic               rst,
    input logic               lane_we,
    input logic [SLOT_W-1:0]  lane_slot,
    input logic [LANE_W-1:0]  lane_idx,
    input logic [31:0]        lane_wdata,
    input logic [31:0]        lane_rdata,
    input logic [SLOT_W-1:0]  wide_sel,
    input logic [OP_BITS-1:0] wide_q,
    input logic               res_we,
    input logic [SLOT_W-1:0]  res_dest,
    input logic               exp_mode,
    input logic [OP_BITS-1:0] res_wdata,
    input logic               collision
);

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (wide_q == '0 && lane_rdata == '0)); // R1

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!lane_we && !res_we) ##1 $stable(wide_sel) |=> $stable(wide_q)); // R3

    AST_RESULT_LANDS: assert property (@(posedge clk) disable iff (rst)
        (res_we && !exp_mode) ##1 (!res_we && !lane_we && wide_sel == $past(res_dest))
        |=> wide_q == $past(res_wdata, 2)); // R5

    AST_LANE_READBACK: assert property (@(posedge clk) disable iff (rst)
        (lane_we && !res_we && !exp_mode) ##1
        (!lane_we && !res_we && !exp_mode && res_dest == $past(lane_slot) && lane_idx == $past(lane_idx))
        |=> lane_rdata == $past(lane_wdata, 2)); // R6

    AST_COLLIDE_SEEN: assert property (@(posedge clk) disable iff (rst)
        (lane_we && res_we) |-> collision); // R7

    AST_COLLIDE_ONLY_BOTH: assert property (@(posedge clk) disable iff (rst)
        collision |-> (lane_we && res_we)); // R7

endmodule

bind operand_store operand_store_chk #(.OP_BITS(OP_BITS), .N_SLOTS(N_SLOTS)) u_chk (
    .clk(clk), .rst(rst), .lane_we(lane_we), .lane_slot(lane_slot), .lane_idx(lane_idx),
    .lane_wdata(lane_wdata), .lane_rdata(lane_rdata), .wide_sel(wide_sel), .wide_q(wide_q),
    .res_we(res_we), .res_dest(res_dest), .exp_mode(exp_mode), .res_wdata(res_wdata),
    .collision(collision)
);

// File: tb/sim_operand_store.sv
`timescale 1ns/1ps
module sim_operand_store;

    localparam int unsigned OPB   = 128;
    localparam int unsigned NS    = 4;
    localparam int unsigned NL    = OPB / 32;
    localparam int unsigned SW    = 2;
    localparam int unsigned LW    = 2;

    logic           clk = 1'b0;
    logic           rst;
    logic           lane_we;
    logic [SW-1:0]  lane_slot;
    logic [LW-1:0]  lane_idx;
    logic [31:0]    lane_wdata;
    logic [31:0]    lane_rdata;
    logic [SW-1:0]  wide_sel;
    logic [OPB-1:0] wide_q;
    logic           res_we;
    logic [SW-1:0]  res_dest;
    logic           exp_mode;
    logic [OPB-1:0] res_wdata;
    logic           collision;

    int n_chk  = 0;
    int n_fail = 0;
    logic [OPB-1:0] model [NS];

    always #2.5 clk = ~clk;

    operand_store #(.OP_BITS(OPB), .N_SLOTS(NS)) u0 (
        .clk(clk), .rst(rst), .lane_we(lane_we), .lane_slot(lane_slot), .lane_idx(lane_idx),
        .lane_wdata(lane_wdata), .lane_rdata(lane_rdata), .wide_sel(wide_sel), .wide_q(wide_q),
        .res_we(res_we), .res_dest(res_dest), .exp_mode(exp_mode), .res_wdata(res_wdata),
        .collision(collision)
    );

    function automatic logic [31:0] pat(input int s, input int w);
        return 32'h9E3779B9 * (s * NL + w + 1);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        lane_we = 0; res_we = 0; exp_mode = 0;
        lane_slot = '0; lane_idx = '0; lane_wdata = '0;
        res_dest = '0; res_wdata = '0;
    endtask

    task automatic chk(input string tag, input logic [OPB-1:0] got, input logic [OPB-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wide_check(input string tag, input int s);
        wide_sel = SW'(s);
        tick();
        chk(tag, wide_q, model[s]);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        wide_sel = '0;
        rst = 1;
        for (int s = 0; s < NS; s++) model[s] = '0;
        repeat (3) tick();
        rst = 0;

        // R1: everything reads zero after reset
        chk("R1 wide after reset", wide_q, '0);
        chk("R1 lane after reset", {96'd0, lane_rdata}, '0);
        for (int s = 0; s < NS; s++) wide_check("R1 unwritten slot", s);
        res_dest = 2'd2; lane_idx = 2'd3; tick();
        chk("R1 unwritten lane", {96'd0, lane_rdata}, '0);

        // R2: fill every lane of every slot over the narrow port
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < NL; w++) begin
                lane_we = 1; lane_slot = SW'(s); lane_idx = LW'(w); lane_wdata = pat(s, w);
                model[s][w*32 +: 32] = pat(s, w);
                tick();
            end
        end
        idle();
        for (int s = 0; s < NS; s++) wide_check("R2 R4 slot after lane fill", s);

        // R4: select change shows only after one clock
        wide_sel = 2'd1;
        #1 chk("R4 old value before edge", wide_q, model[3]);
        tick();
        chk("R4 new value after edge", wide_q, model[1]);

        // R3: enables low, junk on data and address
        lane_slot = 2'd1; lane_idx = 2'd2; lane_wdata = 32'hDEADBEEF;
        res_dest = 2'd1; res_wdata = {4{32'hCAFEF00D}};
        tick(); tick();
        idle();
        wide_check("R3 no write when disabled", 1);

        // R5: full-width result write, neighbours untouched
        res_we = 1; res_dest = 2'd1;
        res_wdata = {32'h11112222, 32'h33334444, 32'h55556666, 32'h77778888};
        model[1] = res_wdata;
        #1 chk("R7 no collision on single write", {127'd0, collision}, '0);
        tick();
        idle();
        wide_check("R5 result slot", 1);
        wide_check("R5 other slot intact", 0);
        wide_check("R5 other slot intact", 2);

        // R6: narrow readback of every lane of the destination slot
        for (int d = 0; d < NS; d++) begin
            for (int w = 0; w < NL; w++) begin
                res_dest = SW'(d); lane_idx = LW'(w);
                tick();
                chk($sformatf("R6 readback slot %0d lane %0d", d, w),
                    {96'd0, lane_rdata}, {96'd0, model[d][w*32 +: 32]});
            end
        end
        idle();

        // R7 R8: simultaneous writes to different slots
        lane_we = 1; lane_slot = 2'd0; lane_idx = 2'd2; lane_wdata = 32'hA5A5A5A5;
        res_we = 1; res_dest = 2'd2; res_wdata = {32'h0BADF00D, 32'h12345678, 32'h9ABCDEF0, 32'h0F0F0F0F};
        model[0][2*32 +: 32] = 32'hA5A5A5A5;
        model[2] = res_wdata;
        #1 chk("R7 collision both writes", {127'd0, collision}, {127'd0, 1'b1});
        tick();
        idle();
        #1 chk("R7 collision cleared", {127'd0, collision}, '0);
        wide_check("R8 lane write other slot", 0);
        wide_check("R8 result write other slot", 2);

        // R8: same slot and lane, result wins
        lane_we = 1; lane_slot = 2'd3; lane_idx = 2'd1; lane_wdata = 32'hFFFFFFFF;
        res_we = 1; res_dest = 2'd3; res_wdata = {32'h01020304, 32'h05060708, 32'h090A0B0C, 32'h0D0E0F10};
        model[3] = res_wdata;
        #1 chk("R7 collision same target", {127'd0, collision}, {127'd0, 1'b1});
        tick();
        idle();
        wide_check("R8 result wins same lane", 3);

        // R9: exponentiation mode forces the top slot
        exp_mode = 1; res_we = 1; res_dest = 2'd0;
        res_wdata = {32'hC0FFEE00, 32'hBEEF0001, 32'hFACE0002, 32'hD00D0003};
        model[3] = res_wdata;
        tick();
        res_we = 0;
        for (int w = 0; w < NL; w++) begin
            lane_idx = LW'(w);
            tick();
            chk($sformatf("R9 forced readback lane %0d", w),
                {96'd0, lane_rdata}, {96'd0, model[3][w*32 +: 32]});
        end
        idle();
        wide_check("R9 top slot written", 3);
        wide_check("R9 selected slot ignored", 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule